// File: doc/BRIEF.md
# Windowed Register File with Global Bank

This block holds the integer registers of a processor that gives each procedure its own register window. Every instruction names a register with one flat 5-bit number. The block turns that number into a physical slot. Numbers 0 to 7 select a global bank that every procedure sees. Numbers 8 to 31 select the outgoing, local or incoming group of the current window. Eight windows sit in a ring, and neighbouring windows share their boundary group. Parameters that a caller places in its outgoing registers therefore show up, without any copy, in the callee's incoming registers.

A call input moves the current window pointer one step down the ring, and a return input moves it one step up. One window is reserved by an invalid mask. A move that would land on it is refused, and the block raises an overflow flag (on a call) or an underflow flag (on a return). The surrounding core uses these flags to start a spill or a fill. The block has two combinational read ports and one write port.

Top module: `winreg_file`

## Requirements
- R1: After reset the window pointer is 0 and every logical register reads as zero in every reachable window.
- R2: Logical register 0 always reads zero. A write to it has no effect, in the same cycle or in any later cycle.
- R3: A lone call moves the pointer to (pointer − 1) mod 8 at the next clock edge. If that target window is marked invalid, the block asserts `ovf_o` in the call cycle and the pointer does not move.
- R4: A lone return moves the pointer to (pointer + 1) mod 8 at the next clock edge. If that target window is marked invalid, the block asserts `unf_o` in the return cycle and the pointer does not move.
- R5: When call and return are asserted together, the pointer does not move and neither flag is raised.
- R6: Logical registers 1–7 address one global bank and read the same in every window.
- R7: Logical registers 8–15 (outs) of window w are the same physical registers as logical registers 24–31 (ins) of window (w − 1) mod 8.
- R8: Logical registers 16–23 (locals) are private to each window. A write in one window never changes the locals of another window.
- R9: When a read port addresses the same physical register that is being written in that cycle, the port returns the new data (write-first bypass).
- R10: A write issued in the same cycle as a call or return is translated through the window that is current before the move.
- R11: After reset, window 1 is the only window marked invalid. The block never makes an invalid window current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Move to the callee window |
| ret_i | input | 1 | Move back to the caller window |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Logical write register |
| wd_i | input | 32 | Write data |
| rs1_i | input | 5 | Logical register for read port 1 |
| rs2_i | input | 5 | Logical register for read port 2 |
| rd1_o | output | 32 | Read port 1 data |
| rd2_o | output | 32 | Read port 2 data |
| cwp_o | output | 3 | Current window pointer |
| ovf_o | output | 1 | Call refused: target window invalid |
| unf_o | output | 1 | Return refused: target window invalid |

## Verification
The bench walks the pointer through the ring in both directions until it reaches the reserved window from each side. A design with the wrong wrap direction or a missing refusal would land on window 1 or would fail to raise the flag. It passes a value from a caller's outs into its callee's ins, including a write issued in the same cycle as the call. A wrong overlap offset, or translating the write through the new window, would return stale data. It also checks that register 0 stays zero when written, that a same-cycle write reaches the read ports through the bypass, and that a call and a return together leave the pointer where it was.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int LREG_W  = 5;
    localparam int GRP     = 8;
    localparam int PER_WIN = 2 * GRP;

    typedef enum logic [1:0] {
        SEG_GLOB = 2'b00,
        SEG_OUT  = 2'b01,
        SEG_LOC  = 2'b10,
        SEG_IN   = 2'b11
    } seg_e;

    typedef enum logic [1:0] {
        MV_NONE,
        MV_CALL,
        MV_RET
    } move_e;

    function automatic seg_e seg_of(input logic [LREG_W-1:0] r);
        return seg_e'(r[4:3]);
    endfunction

    function automatic move_e move_of(input logic c, input logic r);
        if (c && !r) return MV_CALL;
        if (r && !c) return MV_RET;
        return MV_NONE;
    endfunction

endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate #(
    parameter int NWIN = 8,
    parameter int CW   = 3,
    parameter int PW   = 8
) (
    input  logic [CW-1:0]                cwp,
    input  logic [wrf_pkg::LREG_W-1:0]   lreg,
    output logic [PW-1:0]                pidx
);
    import wrf_pkg::*;

    int base_cur;
    int base_up;
    int off;

    always_comb begin
        off      = int'(lreg[2:0]);
        base_cur = GRP + int'(cwp) * PER_WIN;
        base_up  = GRP + ((int'(cwp) + 1) % NWIN) * PER_WIN;
        case (seg_of(lreg))
            SEG_GLOB: pidx = PW'(off);
            SEG_OUT:  pidx = PW'(base_cur + GRP + off);
            SEG_LOC:  pidx = PW'(base_cur + off);
            default:  pidx = PW'(base_up + GRP + off);
        endcase
    end

endmodule

// File: rtl/wrf_wptr.sv
module wrf_wptr #(
    parameter int NWIN = 8,
    parameter int CW   = 3,
    parameter logic [NWIN-1:0] INVALID_MASK = NWIN'(2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_i,
    input  logic          ret_i,
    output logic [CW-1:0] cwp,
    output logic          ovf,
    output logic          unf
);
    import wrf_pkg::*;

    move_e         mv;
    logic [CW-1:0] tgt_dn;
    logic [CW-1:0] tgt_up;

    always_comb begin
        mv     = move_of(call_i, ret_i);
        tgt_dn = CW'((int'(cwp) + NWIN - 1) % NWIN);
        tgt_up = CW'((int'(cwp) + 1) % NWIN);
        ovf    = (mv == MV_CALL) && INVALID_MASK[tgt_dn];
        unf    = (mv == MV_RET)  && INVALID_MASK[tgt_up];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp <= '0;
        end else begin
            case (mv)
                MV_CALL: if (!ovf) cwp <= tgt_dn;
                MV_RET:  if (!unf) cwp <= tgt_up;
                default: cwp <= cwp;
            endcase
        end
    end

    assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cwp == $past(cwp)));
    assert_call_step_R3: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i && !ovf) |=> (int'(cwp) == (int'($past(cwp)) + NWIN - 1) % NWIN));
    assert_unf_hold_R4: assert property (@(posedge clk) disable iff (rst)
        unf |=> (cwp == $past(cwp)));
    assert_ret_step_R4: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && !unf) |=> (int'(cwp) == (int'($past(cwp)) + 1) % NWIN));
    assert_both_still_R5: assert property (@(posedge clk) disable iff (rst)
        (call_i && ret_i) |=> $stable(cwp));
    assert_both_noflag_R5: assert property (@(posedge clk) disable iff (rst)
        (call_i && ret_i) |-> !(ovf || unf));
    assert_cwp_valid_R11: assert property (@(posedge clk) disable iff (rst)
        !INVALID_MASK[cwp]);

endmodule

// File: rtl/wrf_bank.sv
module wrf_bank #(
    parameter int PHYS   = 136,
    parameter int PW     = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PW-1:0]     widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PW-1:0]     ridx1,
    input  logic [PW-1:0]     ridx2,
    output logic [DATA_W-1:0] rdata1,
    output logic [DATA_W-1:0] rdata2
);
    logic [DATA_W-1:0] mem [PHYS];
    logic              wr_ok;

    assign wr_ok = we && (widx != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYS; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[widx] <= wdata;
        end
    end

    always_comb begin
        rdata1 = (wr_ok && widx == ridx1) ? wdata : mem[ridx1];
        rdata2 = (wr_ok && widx == ridx2) ? wdata : mem[ridx2];
    end

    assert_g0_read_R2: assert property (@(posedge clk) disable iff (rst)
        (ridx1 == '0) |-> (rdata1 == '0));
    assert_bypass_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && widx == ridx2) |=> (mem[$past(ridx2)] == $past(rdata2)));

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int DATA_W = 32,
    parameter int NWIN   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    call_i,
    input  logic                    ret_i,
    input  logic                    we_i,
    input  logic [4:0]              wa_i,
    input  logic [DATA_W-1:0]       wd_i,
    input  logic [4:0]              rs1_i,
    input  logic [4:0]              rs2_i,
    output logic [DATA_W-1:0]       rd1_o,
    output logic [DATA_W-1:0]       rd2_o,
    output logic [$clog2(NWIN)-1:0] cwp_o,
    output logic                    ovf_o,
    output logic                    unf_o
);
    import wrf_pkg::*;

    localparam int CW   = $clog2(NWIN);
    localparam int PHYS = GRP + NWIN * PER_WIN;
    localparam int PW   = $clog2(PHYS);
    localparam int NPORT = 3;

    logic [CW-1:0]     cwp;
    logic [LREG_W-1:0] lreg [NPORT];
    logic [PW-1:0]     pidx [NPORT];

    assign lreg[0] = wa_i;
    assign lreg[1] = rs1_i;
    assign lreg[2] = rs2_i;

    wrf_wptr #(.NWIN(NWIN), .CW(CW)) u_wptr (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .cwp(cwp), .ovf(ovf_o), .unf(unf_o)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_xl
        wrf_xlate #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_xl (
            .cwp(cwp), .lreg(lreg[p]), .pidx(pidx[p])
        );
    end

    wrf_bank #(.PHYS(PHYS), .PW(PW), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst(rst), .we(we_i), .widx(pidx[0]), .wdata(wd_i),
        .ridx1(pidx[1]), .ridx2(pidx[2]), .rdata1(rd1_o), .rdata2(rd2_o)
    );

    assign cwp_o = cwp;

    assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(ovf_o && unf_o));
    assert_r0_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rs2_i == '0) |-> (rd2_o == '0));

endmodule

// File: tb/winreg_file_test.sv
module winreg_file_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        call_i, ret_i, we_i;
    logic [4:0]  wa_i, rs1_i, rs2_i;
    logic [31:0] wd_i;
    logic [31:0] rd1_o, rd2_o;
    logic [2:0]  cwp_o;
    logic        ovf_o, unf_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] m [136];
    int          mcwp;
    localparam logic [7:0] BAD = 8'b0000_0010;

    always #10 clk = ~clk;

    winreg_file uut (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i), .we_i(we_i),
        .wa_i(wa_i), .wd_i(wd_i), .rs1_i(rs1_i), .rs2_i(rs2_i),
        .rd1_o(rd1_o), .rd2_o(rd2_o), .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    function automatic int ref_idx(int w, int r);
        if (r < 8)  return r;
        if (r < 16) return 8 + w * 16 + 8 + (r - 8);
        if (r < 24) return 8 + w * 16 + (r - 16);
        return 8 + ((w + 1) % 8) * 16 + 8 + (r - 24);
    endfunction

    function automatic logic [31:0] ref_rd(int r, bit w, int wa, logic [31:0] wd);
        if (w && wa != 0 && ref_idx(mcwp, wa) == ref_idx(mcwp, r)) return wd;
        return m[ref_idx(mcwp, r)];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, bit c, bit r, bit w, int wa, logic [31:0] wd,
                        int a1, int a2);
        bit eo, eu;
        @(negedge clk);
        call_i = c; ret_i = r; we_i = w;
        wa_i = 5'(wa); wd_i = wd; rs1_i = 5'(a1); rs2_i = 5'(a2);
        #2;
        eo = c && !r && BAD[(mcwp + 7) % 8];
        eu = r && !c && BAD[(mcwp + 1) % 8];
        chk({tag, " rd1"}, rd1_o, ref_rd(a1, w, wa, wd));
        chk({tag, " rd2"}, rd2_o, ref_rd(a2, w, wa, wd));
        chk({tag, " cwp"}, 32'(cwp_o), 32'(mcwp));
        chk({tag, " ovf"}, 32'(ovf_o), 32'(eo));
        chk({tag, " unf"}, 32'(unf_o), 32'(eu));
        @(posedge clk);
        if (w && wa != 0) m[ref_idx(mcwp, wa)] = wd;
        if (c && !r && !eo) mcwp = (mcwp + 7) % 8;
        if (r && !c && !eu) mcwp = (mcwp + 1) % 8;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 136; i++) m[i] = '0;
        mcwp = 0;
        rst = 1; call_i = 0; ret_i = 0; we_i = 0;
        wa_i = 0; wd_i = 0; rs1_i = 0; rs2_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        for (int r = 0; r < 32; r += 2) step("R1", 0, 0, 0, 0, 0, r, r + 1);
        // R11, R4: return right after reset lands on the reserved window
        step("R11", 0, 1, 0, 0, 0, 0, 0);
        chk("R11 cwp held", 32'(cwp_o), 32'd0);
        // R2: writes to register 0 are dropped
        step("R2", 0, 0, 1, 0, 32'hFFFF_FFFF, 0, 0);
        step("R2", 0, 0, 0, 0, 0, 0, 0);
        // R6: global visible after a call
        step("R6", 0, 0, 1, 3, 32'hA5A5_0003, 3, 3);
        step("R6", 1, 0, 0, 0, 0, 3, 0);
        step("R6", 0, 0, 0, 0, 0, 3, 3);
        chk("R6 global", rd1_o, 32'hA5A5_0003);
        // R7: outs of caller become ins of callee
        step("R7", 0, 0, 1, 9, 32'hB0B0_0009, 9, 0);
        step("R7", 1, 0, 0, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 0, 25, 9);
        chk("R7 overlap", rd1_o, 32'hB0B0_0009);
        // R8: locals private
        step("R8", 0, 0, 1, 17, 32'hC0C0_0017, 17, 17);
        step("R8", 0, 1, 0, 0, 0, 17, 0);
        step("R8", 0, 0, 0, 0, 0, 17, 17);
        chk("R8 private", rd1_o, 32'h0);
        // R9: bypass
        step("R9", 0, 0, 1, 20, 32'hD0D0_0020, 20, 20);
        chk("R9 bypass", rd2_o, 32'hD0D0_0020);
        // R5: call and return together
        step("R5", 1, 1, 0, 0, 0, 0, 0);
        step("R5", 0, 0, 0, 0, 0, 0, 0);
        // R10: write with call uses the old window
        step("R10", 1, 0, 1, 10, 32'hE0E0_0010, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 26, 10);
        chk("R10 old window", rd1_o, 32'hE0E0_0010);
        // R3: call down to the reserved window
        for (int k = 0; k < 9; k++) step("R3", 1, 0, 0, 0, 0, 8 + k, 24 + k % 8);
        chk("R3 stop", 32'(cwp_o), 32'd2);
        // R4: return up to the reserved window
        for (int k = 0; k < 9; k++) step("R4", 0, 1, 0, 0, 0, 24 + k % 8, 16 + k % 8);
        chk("R4 stop", 32'(cwp_o), 32'd0);

        // constrained random mix
        for (int k = 0; k < 4000; k++) begin
            int sel;
            bit c, r;
            sel = int'($urandom_range(0, 9));
            c = (sel < 3) || (sel == 9);
            r = (sel >= 3 && sel < 6) || (sel == 9);
            step("RND", c, r, bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)),
                 $urandom(), int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule